// File: doc/BRIEF.md
# Host Memory Access Port

This block gives an external host a narrow, strobe-driven path into the on-chip program and data memories while the core keeps running. A single 16-bit bus carries first an address and then a stream of data words. The host raises select and address-latch to set a starting address and a memory-space bit. It then issues read or write strobes. Each completed word access moves the internal address pointer on by one, so a block transfer needs only one address phase.

The host strobes are asynchronous to the core clock. They pass through two-flop synchronisers, and each strobe's rising edge is turned into exactly one request pulse, which then owns one memory cycle. The acknowledge output drops while a request is in flight and returns high when the memory cycle has finished. The host polls it before starting the next strobe. Program words are 24 bits wide and cross the bus as two transfers. An address phase whose top bit is set loads a separate overlay-selection register instead of the address pointer. The address pointer itself cannot be read back through the port.

Top module: `hostmem_port`

## Requirements
- R1: After reset, `hostAck` is 1, `ovlySel` is 0 and `hostAdOut` is 0.
- R2: An address phase (select and address-latch high, then address-latch falling) with bus bit 15 = 0 loads bits 13:0 as the word address and bit 14 as the memory space (0 = program, 1 = data). Later accesses go to that space and address.
- R3: An address phase with bus bit 15 = 1 loads bus bits 7:0 into `ovlySel` and leaves the address pointer and memory space unchanged.
- R4: When a read or write strobe (with select) is first seen at rising edge k, `hostAck` reads 0 after edges k+1 and k+2 and reads 1 again after edge k+3. Read data is valid on `hostAdOut` from that point.
- R5: Each data-memory read or write moves the address up by one, so consecutive transfers hit consecutive words.
- R6: A program word takes two transfers. The first carries bits 23:8. The second carries bits 7:0 in bus bits 7:0, and a read returns zeros in bus bits 15:8. The address advances only after the second transfer.
- R7: A strobe held high for many cycles performs exactly one access.
- R8: Read or write strobes without select perform no access, leave `hostAck` at 1, and do not move the address.
- R9: Address-latch without select changes neither the address nor the memory space.
- R10: A new address phase restarts the program-word pairing, so the next program transfer is treated as the upper part.
- R11: `hostAdOe` is 1 exactly while select and read are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostSel | input | 1 | Host select strobe, active high |
| hostAle | input | 1 | Host address-latch strobe, active high |
| hostRd | input | 1 | Host read strobe, active high |
| hostWr | input | 1 | Host write strobe, active high |
| hostAdIn | input | 16 | Multiplexed address/data from the host |
| hostAdOut | output | 16 | Read data to the host |
| hostAdOe | output | 1 | Drive enable for the host bus |
| hostAck | output | 1 | Acknowledge, high when the port is ready |
| ovlySel | output | 8 | Overlay selection register |

## Verification
A strobe raised midway through a cycle is seen at the next rising edge k. The request pulse follows after edge k+1, the memory cycle runs from edge k+2 to edge k+3, and acknowledge and read data settle after edge k+3. The bench drives every input on the falling edge and samples on the falling edge. It therefore reads the acknowledge at the first through fourth falling edges after a strobe, and it reads data only at the fourth. An address phase commits three edges after address-latch drops, so every address task waits that long before any access starts. Each strobe is released for three cycles so that the synchronisers clear before the next one.

// File: rtl/hmp_pkg.sv
package hmp_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } accState_t;

  typedef struct packed {
    logic captureBus;
    logic latchAddr;
    logic latchOvly;
    logic doRead;
    logic doWrite;
  } dpStrobe_t;

  localparam int STB_SEL = 0;
  localparam int STB_ALE = 1;
  localparam int STB_RD  = 2;
  localparam int STB_WR  = 3;
  localparam int STB_N   = 4;

endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[s] <= '0;
        end else if (s == 0) begin
          chain[s] <= din;
        end else begin
          chain[s] <= chain[(s > 0) ? s - 1 : 0];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl
  import hmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STB_N-1:0] strobeS,
  input  logic             capTop,
  output dpStrobe_t        strb,
  output logic             hostAck
);

  logic      rdReq, wrReq, aleReq;
  logic      rdPrev, wrPrev, alePrev;
  logic      rdRise, wrRise, aleFall;
  accState_t state;
  logic      accWrite;

  assign rdReq  = strobeS[STB_SEL] & strobeS[STB_RD];
  assign wrReq  = strobeS[STB_SEL] & strobeS[STB_WR];
  assign aleReq = strobeS[STB_SEL] & strobeS[STB_ALE];

  assign rdRise  = rdReq & ~rdPrev;
  assign wrRise  = wrReq & ~wrPrev;
  assign aleFall = alePrev & ~aleReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdPrev  <= 1'b0;
      wrPrev  <= 1'b0;
      alePrev <= 1'b0;
    end else begin
      rdPrev  <= rdReq;
      wrPrev  <= wrReq;
      alePrev <= aleReq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      accWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (rdRise || wrRise) begin
            state    <= ST_ACCESS;
            accWrite <= wrRise;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb            = '0;
    strb.captureBus = aleReq;
    strb.latchAddr  = aleFall & ~capTop;
    strb.latchOvly  = aleFall & capTop;
    strb.doRead     = (state == ST_ACCESS) & ~accWrite;
    strb.doWrite    = (state == ST_ACCESS) & accWrite;
  end

  assign hostAck = (state == ST_IDLE) & ~(rdRise | wrRise);

  // R4: acknowledge stays low for the whole memory cycle
  p_ack_low_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS) |-> !hostAck);

  // R4: an idle request moves into the memory cycle on the next edge
  p_req_to_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && (rdRise || wrRise)) |=> (state == ST_ACCESS));

  // R7: a memory cycle lasts one clock only
  p_access_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACCESS) |=> (state == ST_IDLE));

  // R7: a held strobe yields a single request pulse
  p_rise_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdRise || wrRise) |=> !(rdRise || wrRise));

endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath
  import hmp_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 14,
  parameter int PM_W     = 24,
  parameter int PM_DEPTH = 256,
  parameter int DM_DEPTH = 256,
  parameter int OVLY_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpStrobe_t         strb,
  input  logic [BUS_W-1:0]  busS,
  output logic              capTop,
  output logic [BUS_W-1:0]  rdData,
  output logic [OVLY_W-1:0] ovlySel
);

  localparam int PM_IDX_W = $clog2(PM_DEPTH);
  localparam int DM_IDX_W = $clog2(DM_DEPTH);
  localparam int LOW_W    = PM_W - BUS_W;
  localparam int SPACE_B  = ADDR_W;

  logic [BUS_W-1:0]  capReg;
  logic [ADDR_W-1:0] addrReg;
  logic              dmSel;
  logic              halfPhase;
  logic [BUS_W-1:0]  pmHold;
  logic [OVLY_W-1:0] ovlyReg;
  logic [BUS_W-1:0]  rdReg;

  logic [PM_W-1:0]  pmMem [PM_DEPTH];
  logic [BUS_W-1:0] dmMem [DM_DEPTH];

  logic [PM_IDX_W-1:0] pmIdx;
  logic [DM_IDX_W-1:0] dmIdx;
  logic [PM_W-1:0]     pmWord;
  logic [BUS_W-1:0]    dmWord;
  logic                access;
  logic                stepAddr;
  logic                pmWrEn;
  logic                dmWrEn;

  assign pmIdx  = addrReg[PM_IDX_W-1:0];
  assign dmIdx  = addrReg[DM_IDX_W-1:0];
  assign pmWord = pmMem[pmIdx];
  assign dmWord = dmMem[dmIdx];
  assign access = strb.doRead | strb.doWrite;

  // The address advances after every data word, and after the second half of a program word.
  assign stepAddr = access & (dmSel | halfPhase);
  assign pmWrEn   = strb.doWrite & ~dmSel & halfPhase;
  assign dmWrEn   = strb.doWrite & dmSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capReg <= '0;
    end else if (strb.captureBus) begin
      capReg <= busS;
    end
  end

  assign capTop = capReg[BUS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrReg   <= '0;
      dmSel     <= 1'b0;
      halfPhase <= 1'b0;
    end else if (strb.latchAddr) begin
      addrReg   <= capReg[ADDR_W-1:0];
      dmSel     <= capReg[SPACE_B];
      halfPhase <= 1'b0;
    end else if (access) begin
      if (stepAddr) begin
        addrReg <= addrReg + 1'b1;
      end
      if (!dmSel) begin
        halfPhase <= ~halfPhase;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovlyReg <= '0;
    end else if (strb.latchOvly) begin
      ovlyReg <= capReg[OVLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmHold <= '0;
    end else if (strb.doWrite && !dmSel && !halfPhase) begin
      pmHold <= busS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdReg <= '0;
    end else if (strb.doRead) begin
      if (dmSel) begin
        rdReg <= dmWord;
      end else if (!halfPhase) begin
        rdReg <= pmWord[PM_W-1:LOW_W];
      end else begin
        rdReg <= {{(BUS_W-LOW_W){1'b0}}, pmWord[LOW_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pmWrEn) begin
      pmMem[pmIdx] <= {pmHold, busS[LOW_W-1:0]};
    end
    if (dmWrEn) begin
      dmMem[dmIdx] <= busS;
    end
  end

  assign rdData  = rdReg;
  assign ovlySel = ovlyReg;

  // R5: every data-memory access moves the pointer by exactly one
  p_dm_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access && dmSel && !strb.latchAddr) |=> (addrReg == $past(addrReg) + 1'b1));

  // R6: the first half of a program word leaves the pointer in place
  p_pm_first_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !dmSel && !halfPhase && !strb.latchAddr) |=> (halfPhase && $stable(addrReg)));

  // R3: an overlay load does not disturb the address pointer
  p_ovly_keeps_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.latchOvly && !access) |=> ($stable(addrReg) && $stable(dmSel)));

  // R10: a fresh address phase always restarts the pairing
  p_latch_clears_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchAddr |=> !halfPhase);

endmodule

// File: rtl/hostmem_port.sv
module hostmem_port
  import hmp_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int ADDR_W   = 14,
  parameter int PM_W     = 24,
  parameter int PM_DEPTH = 256,
  parameter int DM_DEPTH = 256,
  parameter int OVLY_W   = 8,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostSel,
  input  logic              hostAle,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [BUS_W-1:0]  hostAdIn,
  output logic [BUS_W-1:0]  hostAdOut,
  output logic              hostAdOe,
  output logic              hostAck,
  output logic [OVLY_W-1:0] ovlySel
);

  logic [STB_N-1:0] strobeRaw;
  logic [STB_N-1:0] strobeS;
  logic [BUS_W-1:0] busS;
  logic             capTop;
  dpStrobe_t        strb;

  always_comb begin
    strobeRaw          = '0;
    strobeRaw[STB_SEL] = hostSel;
    strobeRaw[STB_ALE] = hostAle;
    strobeRaw[STB_RD]  = hostRd;
    strobeRaw[STB_WR]  = hostWr;
  end

  hmp_sync #(.WIDTH(STB_N), .STAGES(SYNC_N)) u_strobeSync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (strobeRaw),
    .dout (strobeS)
  );

  hmp_sync #(.WIDTH(BUS_W), .STAGES(SYNC_N)) u_busSync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (hostAdIn),
    .dout (busS)
  );

  hmp_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobeS(strobeS),
    .capTop (capTop),
    .strb   (strb),
    .hostAck(hostAck)
  );

  hmp_datapath #(
    .BUS_W   (BUS_W),
    .ADDR_W  (ADDR_W),
    .PM_W    (PM_W),
    .PM_DEPTH(PM_DEPTH),
    .DM_DEPTH(DM_DEPTH),
    .OVLY_W  (OVLY_W)
  ) u_datapath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .busS   (busS),
    .capTop (capTop),
    .rdData (hostAdOut),
    .ovlySel(ovlySel)
  );

  assign hostAdOe = hostSel & hostRd;

endmodule

// File: tb/hostmem_port_test.sv
module hostmem_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostAle = 1'b0;
  logic        hostRd = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostAdIn = '0;
  logic [15:0] hostAdOut;
  logic        hostAdOe;
  logic        hostAck;
  logic [7:0]  ovlySel;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  hostmem_port uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hostSel  (hostSel),
    .hostAle  (hostAle),
    .hostRd   (hostRd),
    .hostWr   (hostWr),
    .hostAdIn (hostAdIn),
    .hostAdOut(hostAdOut),
    .hostAdOe (hostAdOe),
    .hostAck  (hostAck),
    .ovlySel  (ovlySel)
  );

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic latchPhase(input logic [15:0] val);
    @(negedge clk);
    hostAdIn = val; hostSel = 1'b1; hostAle = 1'b1;
    waitNeg(3);
    hostAle = 1'b0; hostSel = 1'b0;
    waitNeg(3);
  endtask

  task automatic hostWrite(input logic [15:0] val);
    @(negedge clk);
    hostAdIn = val; hostSel = 1'b1; hostWr = 1'b1;
    waitNeg(4);
    hostWr = 1'b0; hostSel = 1'b0;
    waitNeg(3);
  endtask

  task automatic hostRead(output logic [15:0] val);
    @(negedge clk);
    hostSel = 1'b1; hostRd = 1'b1;
    waitNeg(4);
    val = hostAdOut;
    hostRd = 1'b0; hostSel = 1'b0;
    waitNeg(3);
  endtask

  task automatic t_reset();
    check("R1 ack", {23'd0, hostAck}, 24'd1);
    check("R1 ovly", {16'd0, ovlySel}, 24'd0);
    check("R1 data", {8'd0, hostAdOut}, 24'd0);
  endtask

  task automatic t_ackTiming();
    logic [3:0] seen;
    latchPhase(16'h4005);
    @(negedge clk);
    hostAdIn = 16'h1234; hostSel = 1'b1; hostWr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen[i] = hostAck;
    end
    hostWr = 1'b0; hostSel = 1'b0;
    waitNeg(3);
    check("R4 ack sequence", {20'd0, seen}, 24'h9); // 1,0,0,1 at bits 0..3
  endtask

  task automatic t_dmStream();
    logic [15:0] r;
    latchPhase(16'h4010);
    hostWrite(16'hA001); hostWrite(16'hA002); hostWrite(16'hA003);
    latchPhase(16'h4010);
    hostRead(r); check("R5 dm word0", {8'd0, r}, 24'h00A001);
    hostRead(r); check("R5 dm word1", {8'd0, r}, 24'h00A002);
    hostRead(r); check("R2 dm word2", {8'd0, r}, 24'h00A003);
    latchPhase(16'h4012);
    hostRead(r); check("R2 dm direct", {8'd0, r}, 24'h00A003);
  endtask

  task automatic t_pmSplit();
    logic [15:0] hi, lo;
    latchPhase(16'h0020);
    hostWrite(16'hBEEF); hostWrite(16'hFF5A);
    hostWrite(16'h1357); hostWrite(16'h00C3);
    latchPhase(16'h0020);
    hostRead(hi); hostRead(lo);
    check("R6 pm word0", {hi[15:0], lo[7:0]}, 24'hBEEF5A);
    check("R6 pm low upper zero", {16'd0, lo[15:8]}, 24'd0);
    hostRead(hi); hostRead(lo);
    check("R6 pm word1", {hi[15:0], lo[7:0]}, 24'h1357C3);
    latchPhase(16'h0021);
    hostRead(hi); hostRead(lo);
    check("R6 pm second addr", {hi[15:0], lo[7:0]}, 24'h1357C3);
  endtask

  task automatic t_overlay();
    logic [15:0] r;
    latchPhase(16'h4040);
    hostWrite(16'hC0DE);
    latchPhase(16'h80A5);
    check("R3 ovly value", {16'd0, ovlySel}, 24'h0000A5);
    hostWrite(16'hD00D);
    latchPhase(16'h4040);
    hostRead(r); check("R3 addr kept 0", {8'd0, r}, 24'h00C0DE);
    hostRead(r); check("R3 addr kept 1", {8'd0, r}, 24'h00D00D);
    check("R3 ovly held", {16'd0, ovlySel}, 24'h0000A5);
  endtask

  task automatic t_heldStrobe();
    logic [15:0] r;
    latchPhase(16'h4050);
    @(negedge clk);
    hostAdIn = 16'h1111; hostSel = 1'b1; hostWr = 1'b1;
    waitNeg(12);
    check("R7 ack while held", {23'd0, hostAck}, 24'd1);
    hostWr = 1'b0; hostSel = 1'b0;
    waitNeg(3);
    hostWrite(16'h2222);
    latchPhase(16'h4050);
    hostRead(r); check("R7 single access 0", {8'd0, r}, 24'h001111);
    hostRead(r); check("R7 single access 1", {8'd0, r}, 24'h002222);
  endtask

  task automatic t_noSelect();
    logic [15:0] r;
    logic        ackLow;
    latchPhase(16'h4060);
    hostWrite(16'h3333);
    ackLow = 1'b0;
    @(negedge clk);
    hostAdIn = 16'h9999; hostWr = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!hostAck) ackLow = 1'b1;
    end
    hostWr = 1'b0; hostRd = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!hostAck) ackLow = 1'b1;
    end
    check("R11 oe rd without sel", {23'd0, hostAdOe}, 24'd0);
    hostRd = 1'b0;
    waitNeg(3);
    check("R8 ack stays high", {23'd0, ackLow}, 24'd0);
    hostWrite(16'h4444);
    latchPhase(16'h4060);
    hostRead(r); check("R8 no access 0", {8'd0, r}, 24'h003333);
    hostRead(r); check("R8 no access 1", {8'd0, r}, 24'h004444);
  endtask

  task automatic t_aleNoSelect();
    logic [15:0] r;
    latchPhase(16'h4070);
    @(negedge clk);
    hostAdIn = 16'h0060; hostAle = 1'b1;
    waitNeg(3);
    hostAle = 1'b0;
    waitNeg(3);
    hostWrite(16'h5555);
    latchPhase(16'h4070);
    hostRead(r); check("R9 ale ignored", {8'd0, r}, 24'h005555);
  endtask

  task automatic t_phaseRestart();
    logic [15:0] hi, lo;
    latchPhase(16'h0030);
    hostWrite(16'h7777);
    latchPhase(16'h0030);
    hostWrite(16'h6543); hostWrite(16'h0021);
    latchPhase(16'h0030);
    hostRead(hi); hostRead(lo);
    check("R10 pairing restarts", {hi[15:0], lo[7:0]}, 24'h654321);
  endtask

  task automatic t_outputEnable();
    @(negedge clk);
    hostSel = 1'b1; hostRd = 1'b1;
    #1;
    check("R11 oe on", {23'd0, hostAdOe}, 24'd1);
    waitNeg(4);
    hostRd = 1'b0;
    #1;
    check("R11 oe off", {23'd0, hostAdOe}, 24'd0);
    hostSel = 1'b0;
    waitNeg(3);
  endtask

  initial begin
    waitNeg(3);
    rst_n = 1'b1;
    waitNeg(2);
    t_reset();
    t_ackTiming();
    t_dmStream();
    t_pmSplit();
    t_overlay();
    t_heldStrobe();
    t_noSelect();
    t_aleNoSelect();
    t_phaseRestart();
    t_outputEnable();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule